// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. The line carries frames of ten bit periods: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A free-running tick at sixteen times the nominal bit rate comes from a shared rate generator. The block uses this tick to place one sample near the middle of every bit period. The serial input passes through a two-stage synchronizer before any logic reads it.

A falling edge on the synchronized line starts a frame and raises the busy flag. A 16-step phase counter, advanced by the tick, times each bit period. The line is sampled when the phase counter reaches its eighth step. If the line is high again at the middle of the start bit, the edge is treated as a glitch and dropped. A separate 3-bit counter counts the data bits. When the sixteenth step of the stop bit arrives, the assembled byte is copied into a hold register and a single-cycle strobe is raised, but only if the stop bit was sampled high. A low stop bit drops the byte silently. Busy clears at the end of every frame, whether the frame was accepted, glitched or rejected.

Top module: `serial_byte_rx`

## Requirements
- R1: While reset is asserted (rst_n low), rx_byte reads 0, rx_strobe reads 0 and rx_busy reads 0.
- R2: A high-to-low transition on the synchronized line, seen while idle, sets rx_busy within three clock cycles. rx_busy stays high through the data bits of the frame.
- R3: Data bits are sampled at the eighth tick of each bit period and assembled least significant bit first. The first data bit after the start bit ends up in rx_byte bit 0.
- R4: For each accepted frame, rx_strobe is high for exactly one clock cycle. rx_byte carries the new byte in that cycle.
- R5: If the line is high at the middle-of-start sample, the frame is abandoned. rx_busy clears, no strobe is raised and rx_byte keeps its previous value.
- R6: A stop bit sampled low discards the byte. No strobe is raised and rx_byte keeps its previous value.
- R7: Frames are received correctly when the sender's bit period is within plus or minus 2% of sixteen ticks.
- R8: rx_byte changes only in a cycle in which rx_strobe is high.
- R9: rx_busy clears at the end of the stop bit, in the same cycle as any strobe. A following frame that begins after an idle gap is then received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at sixteen times the nominal bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | 8 | Hold register with the last accepted byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is loaded |
| rx_busy | output | 1 | High while a frame is in progress |

## Verification
Two situations are hard to reach from the ports: a sender whose rate is off nominal, and a line pulse too short to be a start bit. For the first, the bench times each bit period in nanoseconds, independently of the tick, at 98%, 100% and 102% of nominal. This drifts the sample points toward the bit edges. For the second, a low pulse shorter than half a bit period is sent, so the line has recovered before the middle-of-start sample. Frames with a low stop bit are mixed between good frames, which shows that the hold register keeps the earlier byte.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_serial,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_strobe,
  output logic              rx_busy
);
  localparam int PH_W  = $clog2(OSR);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} st_t;

  st_t               st_q;
  logic [2:0]        sync_q;
  logic [PH_W-1:0]   phase_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg_q;
  logic              stop_ok_q;

  wire line_q   = sync_q[1];
  wire fall     = sync_q[2] & ~sync_q[1];
  wire at_mid   = tick16 && phase_q == PH_MID;
  wire at_end   = tick16 && phase_q == PH_LAST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_serial};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      phase_q   <= '0;
      bit_cnt   <= '0;
      shreg_q   <= '0;
      stop_ok_q <= 1'b0;
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
      rx_busy   <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (st_q != ST_IDLE && tick16) phase_q <= phase_q + 1'b1;
      case (st_q)
        ST_IDLE: if (fall) begin
          st_q    <= ST_START;
          phase_q <= '0;
          bit_cnt <= '0;
          rx_busy <= 1'b1;
        end
        ST_START: begin
          if (at_mid && line_q) begin
            st_q    <= ST_IDLE;
            rx_busy <= 1'b0;
          end else if (at_end) st_q <= ST_DATA;
        end
        ST_DATA: begin
          if (at_mid) shreg_q <= {line_q, shreg_q[DATA_W-1:1]};
          if (at_end) begin
            if (bit_cnt == BIT_LAST) begin
              st_q    <= ST_STOP;
              bit_cnt <= '0;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_mid) stop_ok_q <= line_q;
          if (at_end) begin
            st_q    <= ST_IDLE;
            rx_busy <= 1'b0;
            if (stop_ok_q) begin
              rx_byte   <= shreg_q;
              rx_strobe <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);
  assert_byte_only_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_strobe);
  assert_strobe_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> (!rx_busy && $past(rx_busy)));
  assert_busy_needs_low_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> !$past(line_q));
  assert_strobe_needs_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> ($past(st_q) == ST_STOP && $past(stop_ok_q)));
  assert_glitch_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_START && st_q == ST_IDLE) |-> (!rx_busy && !rx_strobe));
endmodule

// File: tb/test_serial_byte_rx.sv
`timescale 1ns/1ps
module test_serial_byte_rx;
  localparam real NOM_NS = 320.0;  // 16 ticks x 4 clocks x 5 ns

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_serial = 1'b1;
  logic [7:0] rx_byte;
  logic rx_strobe, rx_busy;
  int checks = 0, fails = 0, strobes = 0, long_strobe = 0;
  logic prev_strobe = 1'b0;
  logic [1:0] tdiv = '0;
  logic mid_busy;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (rx_strobe) strobes++;
    if (rx_strobe && prev_strobe) long_strobe++;
    prev_strobe = rx_strobe;
  end

  serial_byte_rx i_serial_byte_rx (.clk(clk), .rst_n(rst_n), .tick16(tick16),
    .rx_serial(rx_serial), .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rx_busy(rx_busy));

  // {stop bit value, rate: 0 nominal / 1 fast -2% / 2 slow +2%, data}
  localparam logic [10:0] VEC [0:9] = '{
    {1'b1, 2'd0, 8'h55}, {1'b1, 2'd1, 8'hA3}, {1'b1, 2'd2, 8'h3C},
    {1'b1, 2'd0, 8'h00}, {1'b1, 2'd1, 8'hFF}, {1'b1, 2'd2, 8'h81},
    {1'b0, 2'd0, 8'h6E}, {1'b1, 2'd0, 8'h92}, {1'b0, 2'd2, 8'h7F},
    {1'b1, 2'd1, 8'h01}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stop, input real bit_ns);
    rx_serial = 1'b0;
    #(bit_ns);
    for (int i = 0; i < 8; i++) begin
      rx_serial = d[i];
      if (i == 3) begin #(bit_ns/2); mid_busy = rx_busy; #(bit_ns/2); end
      else #(bit_ns);
    end
    rx_serial = stop;
    #(bit_ns);
    rx_serial = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] good = 8'h00;
    int s0;
    #40;
    @(negedge clk);
    check(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
    check(rx_strobe == 1'b0, "R1 strobe", rx_strobe, 0);
    check(rx_busy == 1'b0, "R1 busy", rx_busy, 0);
    rst_n = 1'b1;
    #(NOM_NS*2);

    foreach (VEC[k]) begin
      real bns;
      bns = (VEC[k][9:8] == 2'd1) ? NOM_NS*0.98 : (VEC[k][9:8] == 2'd2) ? NOM_NS*1.02 : NOM_NS;
      s0 = strobes;
      send(VEC[k][7:0], VEC[k][10], bns);
      #(NOM_NS*2);
      @(negedge clk);
      if (VEC[k][10]) good = VEC[k][7:0];
      check(mid_busy == 1'b1, "R2 busy mid-frame", mid_busy, 1);
      check(strobes - s0 == (VEC[k][10] ? 1 : 0), VEC[k][10] ? "R4 one strobe" : "R6 no strobe",
            strobes - s0, VEC[k][10] ? 1 : 0);
      check(rx_byte == good, VEC[k][10] ? "R3/R7 byte" : "R6 byte kept", rx_byte, good);
      check(rx_busy == 1'b0, "R9 busy clear", rx_busy, 0);
    end
    check(long_strobe == 0, "R4 strobe width", long_strobe, 0);

    // glitch: low pulse shorter than half a bit
    s0 = strobes;
    rx_serial = 1'b0;
    #60;
    check(rx_busy == 1'b1, "R2 busy on edge", rx_busy, 1);
    #40;
    rx_serial = 1'b1;
    #(NOM_NS*2);
    @(negedge clk);
    check(rx_busy == 1'b0, "R5 glitch busy", rx_busy, 0);
    check(strobes == s0, "R5 glitch strobe", strobes - s0, 0);
    check(rx_byte == good, "R5 glitch byte", rx_byte, good);

    // frame after glitch is still received
    s0 = strobes;
    send(8'hC5, 1'b1, NOM_NS);
    #(NOM_NS*2);
    @(negedge clk);
    check(strobes - s0 == 1, "R9 next frame strobe", strobes - s0, 1);
    check(rx_byte == 8'hC5, "R9 next frame byte", rx_byte, 8'hC5);
    check(rx_busy == 1'b0, "R9 idle", rx_busy, 0);
    finish_run();
  end
endmodule